// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches eight general-purpose input pins, arranged as two ports of four pins each. Each pin passes through a two-flop synchronizer. The synchronized level is then compared with an old value that software keeps for that pin. Whenever the two differ, the pin's interrupt state bit latches high. An event line to the interrupt fabric is raised for every pending pin whose enable bit is set.

The block has no edge-selection register. Software tells the direction of an edge from the old value. A pending pin with old value 0 has seen a low-to-high change, and one with old value 1 has seen a high-to-low change. Software acknowledges a pin by writing a one to its set command bit or its clear command bit. This loads the old value with 1 or 0 and clears the pending state. If the pin still disagrees with the new old value, the pin is pending again one cycle later.

A two-word register port gives access to the block. Address 0 is the status/command word and address 1 is the event enable word. Reads are combinational.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every old value, interrupt state and enable bit is 0, both register words read 0 and `irq_event` is low.
- R2: Pin `i` is bit `i` of `pin_in` (port 0 = bits 3:0, port 1 = bits 7:4). A change on a pin sets its interrupt state (status bit `i`) after the third rising clock edge that follows the change, and not earlier.
- R3: Once set, an interrupt state bit stays set while no command for that pin is written, even when the pin returns to its old value.
- R4: Writing 1 to status bit `24+i` (clear command) makes old value bit `8+i` read 0 and clears state bit `i` at that edge.
- R5: Writing 1 to status bit `16+i` (set command) makes old value bit `8+i` read 1 and clears state bit `i` at that edge.
- R6: If the synchronized pin differs from the old value left by a command, the state bit is set again on the next clock edge.
- R7: When the set and clear commands for the same pin are written together, the clear command wins.
- R8: Status bits 31:16 always read 0. Writes to bits 15:0 of the status word are ignored.
- R9: The enable word at address 1 keeps write data bits 7:0 (bit `i` enables pin `i`) and reads them back with bits 31:8 at 0.
- R10: `irq_event` is high exactly when some pin has both its state bit and its enable bit set. It follows register changes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Raw pin levels, bit i = pin i |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_addr | input | 1 | 0 = status/command word, 1 = enable word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| irq_event | output | 1 | OR of pending-and-enabled pins |

## Verification
The detector is driven with the following patterns:
- A rising pulse that returns low before it is acknowledged. This separates sticky capture from level following, and the acknowledge that follows shows the re-arm path.
- A clean rise acknowledged with set, then a fall acknowledged with clear. This checks that the old value alone encodes the direction.
- A pin held high while set and clear are written together. This exposes the command priority.
- A pin that becomes pending while masked, and is then unmasked. This checks that the event line follows the enable word without delay.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef struct packed {
    logic old;
    logic st;
  } pin_state_t;

  // Next state of one pin: clear command over set command over detection.
  function automatic pin_state_t pin_next(pin_state_t cur, logic diff,
                                          logic set_c, logic clr_c);
    pin_state_t n;
    if (clr_c) begin
      n.old = 1'b0;
      n.st  = 1'b0;
    end else if (set_c) begin
      n.old = 1'b1;
      n.st  = 1'b0;
    end else begin
      n.old = cur.old;
      n.st  = cur.st | diff;
    end
    return n;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_irq_pin_cell.sv
module gpio_irq_pin_cell
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic set_cmd,
  input  logic clr_cmd,
  output logic diff,
  output logic old_q,
  output logic st_q
);
  pin_state_t cur, nxt;

  assign diff = level ^ cur.old;
  assign nxt  = pin_next(cur, diff, set_cmd, clr_cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  assign old_q = cur.old;
  assign st_q  = cur.st;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int N_PORTS       = 2,
  parameter int PINS_PER_PORT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  pin_in,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_event
);
  localparam int NPINS   = N_PORTS * PINS_PER_PORT;
  localparam int OFS_OLD = NPINS;
  localparam int OFS_SET = 2 * NPINS;
  localparam int OFS_CLR = 3 * NPINS;
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_ENABLE = 1'b1;

  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] ack_set, ack_clr;
  logic [NPINS-1:0] pin_diff, old_q, st_q;
  logic [NPINS-1:0] en_q;
  logic             wr_status, wr_enable;
  logic             unused_wdata;

  assign wr_status    = reg_wr && (reg_addr == ADDR_STATUS);
  assign wr_enable    = reg_wr && (reg_addr == ADDR_ENABLE);
  assign ack_set      = wr_status ? reg_wdata[OFS_SET +: NPINS] : '0;
  assign ack_clr      = wr_status ? reg_wdata[OFS_CLR +: NPINS] : '0;
  assign unused_wdata = ^reg_wdata[OFS_OLD +: NPINS];

  gpio_irq_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_irq_pin_cell u_cell (
      .clk(clk), .rst_n(rst_n), .level(pin_sync[i]),
      .set_cmd(ack_set[i]), .clr_cmd(ack_clr[i]),
      .diff(pin_diff[i]), .old_q(old_q[i]), .st_q(st_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (wr_enable) en_q <= reg_wdata[NPINS-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_STATUS) begin
      reg_rdata[0 +: NPINS]       = st_q;
      reg_rdata[OFS_OLD +: NPINS] = old_q;
    end else begin
      reg_rdata[NPINS-1:0] = en_q;
    end
  end

  assign irq_event = |(st_q & en_q);
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] ack_set,
  input logic [NPINS-1:0] ack_clr,
  input logic [NPINS-1:0] pin_diff,
  input logic [NPINS-1:0] old_q,
  input logic [NPINS-1:0] st_q
);
  // R3: a pending pin with no command stays pending
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ~(ack_set | ack_clr)) != '0) |=>
      ((st_q & $past(st_q & ~(ack_set | ack_clr))) == $past(st_q & ~(ack_set | ack_clr))));

  // R4, R7: clear command zeroes old value and state
  p_clear_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr != '0) |=> (((old_q | st_q) & $past(ack_clr)) == '0));

  // R5: set command alone loads old value 1 and clears state
  p_set_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_set & ~ack_clr) != '0) |=>
      (((~old_q | st_q) & $past(ack_set & ~ack_clr)) == '0));

  // R8: old values move only through commands
  p_old_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_set | ack_clr) == '0) |=> $stable(old_q));

  // R2, R6: a state bit only rises where the pin disagreed a cycle before
  p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ~$past(st_q) & ~$past(pin_diff)) == '0));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_set(ack_set), .ack_clr(ack_clr),
  .pin_diff(pin_diff), .old_q(old_q), .st_q(st_q)
);

// File: tb/sim_gpio_edge_irq.sv
`timescale 1ns/100ps
module sim_gpio_edge_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_in = '0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_event;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_edge_irq u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_event(irq_event)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_check(input string req, input logic a, input logic [31:0] exp);
    reg_addr = a;
    #0.5;
    check(req, reg_rdata, exp);
  endtask

  task automatic t_reset;
    rd_check("R1", 1'b0, 32'h0);
    rd_check("R1", 1'b1, 32'h0);
    check("R1", {31'b0, irq_event}, 32'h0);
  endtask

  // pulse on pin 5, sticky, then set ack re-arms, clear ack finishes
  task automatic t_pulse_rearm;
    pin_in[5] = 1'b1;
    tick(2);
    rd_check("R2", 1'b0, 32'h0);
    tick(1);
    rd_check("R2", 1'b0, 32'h0000_0020);
    pin_in[5] = 1'b0;
    tick(5);
    rd_check("R3", 1'b0, 32'h0000_0020);
    wr(1'b0, 32'h1 << 21);
    rd_check("R5", 1'b0, 32'h0000_2000);
    tick(1);
    rd_check("R6", 1'b0, 32'h0000_2020);
    wr(1'b0, 32'h1 << 29);
    rd_check("R4", 1'b0, 32'h0);
    tick(3);
    rd_check("R4", 1'b0, 32'h0);
  endtask

  // rise and fall on pin 2, each acknowledged in its own direction
  task automatic t_rise_fall;
    pin_in[2] = 1'b1;
    tick(3);
    rd_check("R2", 1'b0, 32'h0000_0004);
    wr(1'b0, 32'h1 << 18);
    rd_check("R5", 1'b0, 32'h0000_0400);
    tick(3);
    rd_check("R5", 1'b0, 32'h0000_0400);
    pin_in[2] = 1'b0;
    tick(3);
    rd_check("R2", 1'b0, 32'h0000_0404);
    wr(1'b0, 32'h1 << 26);
    rd_check("R4", 1'b0, 32'h0);
  endtask

  // set and clear together on pin 0 while it is high
  task automatic t_both_cmds;
    pin_in[0] = 1'b1;
    tick(3);
    rd_check("R2", 1'b0, 32'h0000_0001);
    wr(1'b0, (32'h1 << 16) | (32'h1 << 24));
    rd_check("R7", 1'b0, 32'h0);
    tick(1);
    rd_check("R6", 1'b0, 32'h0000_0001);
    wr(1'b0, 32'h1 << 16);
    pin_in[0] = 1'b0;
    tick(3);
    rd_check("R2", 1'b0, 32'h0000_0101);
    wr(1'b0, 32'h1 << 24);
    rd_check("R4", 1'b0, 32'h0);
  endtask

  task automatic t_readonly;
    wr(1'b0, 32'h0000_FFFF);
    rd_check("R8", 1'b0, 32'h0);
    tick(2);
    rd_check("R8", 1'b0, 32'h0);
  endtask

  // pin 6 pending while masked, then unmasked
  task automatic t_enable;
    wr(1'b1, 32'hFFFF_FFA5);
    rd_check("R9", 1'b1, 32'h0000_00A5);
    pin_in[6] = 1'b1;
    tick(3);
    rd_check("R2", 1'b0, 32'h0000_0040);
    check("R10", {31'b0, irq_event}, 32'h0);
    wr(1'b1, 32'h0000_00E5);
    check("R10", {31'b0, irq_event}, 32'h1);
    wr(1'b0, 32'h1 << 22);
    check("R10", {31'b0, irq_event}, 32'h0);
    pin_in[6] = 1'b0;
    tick(3);
    check("R10", {31'b0, irq_event}, 32'h1);
    wr(1'b0, 32'h1 << 30);
    check("R10", {31'b0, irq_event}, 32'h0);
    rd_check("R9", 1'b1, 32'h0000_00E5);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_pulse_rearm();
    t_rise_fall();
    t_both_cmds();
    t_readonly();
    t_enable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule